// File: doc/BRIEF.md
# Row/Column Display Write Decoder

This block sits behind a serial receiver that has already turned the SPI or I2C bit stream into whole bytes. A frame signal marks one transfer. It is high while SPI select is active, or from the I2C address match until the stop condition. The decoder sorts each byte into one of three kinds: a row address, a column address or a display data byte. It then issues one write per data byte to the on-screen character RAM or to the attribute RAM.

Three packet shapes are accepted:
- **Full triples**: row, column and data are sent again for every write.
- **Column/data pairs**: one row is followed by repeated column and data pairs.
- **Streaming**: one row and one column are followed by any number of data bytes. The position advances by itself after each write.

The decoder can move between the two non-streaming shapes at any time. Once streaming starts, it stays streaming until the frame ends.

Character codes are 9 bits wide. The top code bit comes from the column byte and the low eight bits come from the data byte. This lets 512 glyphs be addressed while each data byte stays one byte long.

Top module: `disp_wr_decoder`

## Requirements
- R1: While reset is low, and in the first cycle after it, `wr_en_o` is 0 and the row, column, code and select outputs are all 0.
- R2: A byte with bit 7 = 1 is a row byte. Its bits 4:0 set the row. Its bit 5 chooses the target RAM: 0 for character codes, 1 for attributes. The chosen target is shown on `wr_attr_o` for every later write.
- R3: A byte with bit 7 = 0, arriving where a row or column is expected, is a column byte. Its bits 4:0 set the column. Bit 6 = 1 enters streaming. Bit 6 = 0 expects a single data byte next.
- R4: A character write outputs the code {column bit 5, data byte}. An attribute write ignores column bit 5 and outputs code bit 8 as 0.
- R5: Each accepted data byte gives exactly one write. `wr_en_o` is high in the cycle after the byte is presented, and the current row and column are shown with it.
- R6: After a data byte in non-streaming mode, the next byte selects what follows. A byte with bit 7 = 1 starts a new row. A byte with bit 7 = 0 is a new column, and the row is kept. Either mode may follow.
- R7: In streaming mode each write uses the current position, and the column then steps by one. Column 31 wraps to 0 and the row steps by one, with row 31 wrapping to 0.
- R8: In streaming mode every byte is data, including bytes with bit 7 = 1. Code bit 8 keeps the value from the column byte.
- R9: When the frame ends, the decoder returns to idle. In idle, bytes with bit 7 = 0 are dropped without any write until a row byte arrives.
- R10: A byte presented with `byte_valid_i` low, or while `frame_i` is low, causes no write and does not change the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | High for the duration of a transfer frame |
| byte_valid_i | input | 1 | A received byte is presented this cycle |
| byte_i | input | 8 | Received byte |
| wr_en_o | output | 1 | One-cycle RAM write strobe |
| wr_row_o | output | 5 | Row of the write |
| wr_col_o | output | 5 | Column of the write |
| wr_code_o | output | 9 | Character code or attribute value |
| wr_attr_o | output | 1 | 1 = attribute RAM, 0 = character RAM |

## Verification
The assertions check, on every cycle, the properties that depend only on nearby cycles:
- a write never follows an idle state or an invalid byte;
- attribute writes have code bit 8 clear;
- two back-to-back streaming writes step the column and row by one, wrapping correctly;
- code bit 8 and the RAM select stay fixed during a stream.

Whether bytes are classified correctly as rows, columns or data, and which address and code a given sequence produces, can only be shown by the bench's scenarios. This covers the field values, switching between the packet shapes, the idle state dropping stray column bytes, and a frame end clearing a stream.

// File: rtl/dwd_pkg.sv
package dwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COL    = 3'd1,
        ST_DATA   = 3'd2,
        ST_NEXT   = 3'd3,
        ST_STREAM = 3'd4
    } dwd_state_e;

    localparam int KIND_BIT   = 7;
    localparam int STREAM_BIT = 6;
    localparam int SEL_BIT    = 5;

endpackage

// File: rtl/dwd_classify.sv
module dwd_classify #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_row_o,
    output logic              is_stream_o,
    output logic              sel_o,
    output logic [ADDR_W-1:0] addr_o
);
    import dwd_pkg::*;

    always_comb begin
        is_row_o    = byte_i[KIND_BIT];
        is_stream_o = byte_i[STREAM_BIT];
        sel_o       = byte_i[SEL_BIT];
        addr_o      = byte_i[ADDR_W-1:0];
    end

endmodule

// File: rtl/dwd_addr_step.sv
module dwd_addr_step #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] row_i,
    input  logic [ADDR_W-1:0] col_i,
    output logic [ADDR_W-1:0] row_o,
    output logic [ADDR_W-1:0] col_o
);
    localparam logic [ADDR_W-1:0] COL_LAST = {ADDR_W{1'b1}};

    always_comb begin
        col_o = col_i + 1'b1;
        row_o = row_i;
        if (col_i == COL_LAST) begin
            col_o = '0;
            row_o = row_i + 1'b1;
        end
    end

endmodule

// File: rtl/dwd_seq.sv
module dwd_seq #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              is_row_i,
    input  logic              is_stream_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] step_row_i,
    input  logic [ADDR_W-1:0] step_col_i,
    output logic [ADDR_W-1:0] row_o,
    output logic [ADDR_W-1:0] col_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_row_o,
    output logic [ADDR_W-1:0] wr_col_o,
    output logic [BYTE_W:0]   wr_code_o,
    output logic              wr_attr_o
);
    import dwd_pkg::*;

    localparam logic [ADDR_W-1:0] COL_LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        dwd_state_e        st;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic              hi;
        logic              attr;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_row;
        logic [ADDR_W-1:0] wr_col;
        logic [BYTE_W:0]   wr_code;
        logic              wr_attr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        if (!frame_i) begin
            s_d.st = ST_IDLE;
        end else if (valid_i) begin
            case (s_q.st)
                ST_IDLE: begin
                    if (is_row_i) begin
                        s_d.row  = addr_i;
                        s_d.attr = sel_i;
                        s_d.st   = ST_COL;
                    end
                end
                ST_COL, ST_NEXT: begin
                    if (is_row_i) begin
                        s_d.row  = addr_i;
                        s_d.attr = sel_i;
                        s_d.st   = ST_COL;
                    end else begin
                        s_d.col = addr_i;
                        s_d.hi  = sel_i & ~s_q.attr;
                        s_d.st  = is_stream_i ? ST_STREAM : ST_DATA;
                    end
                end
                ST_DATA, ST_STREAM: begin
                    s_d.wr_en   = 1'b1;
                    s_d.wr_row  = s_q.row;
                    s_d.wr_col  = s_q.col;
                    s_d.wr_code = {s_q.hi, byte_i};
                    s_d.wr_attr = s_q.attr;
                    if (s_q.st == ST_DATA) begin
                        s_d.st = ST_NEXT;
                    end else begin
                        s_d.row = step_row_i;
                        s_d.col = step_col_i;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign row_o     = s_q.row;
    assign col_o     = s_q.col;
    assign wr_en_o   = s_q.wr_en;
    assign wr_row_o  = s_q.wr_row;
    assign wr_col_o  = s_q.wr_col;
    assign wr_code_o = s_q.wr_code;
    assign wr_attr_o = s_q.wr_attr;

    // R5, R10: a write comes only from a byte presented inside a frame
    p_write_from_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(valid_i && frame_i));

    // R9: idle never produces a write
    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(s_q.st) != ST_IDLE);

    // R4: attribute writes never carry code bit 8
    p_attr_code_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_attr_o) |-> !wr_code_o[BYTE_W]);

    // R7: back-to-back streaming writes step the column inside a row
    p_stream_col_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o) && s_q.st == ST_STREAM && $past(s_q.st) == ST_STREAM
         && $past(wr_col_o) != COL_LAST)
        |-> (wr_col_o == ADDR_W'($past(wr_col_o) + 1'b1)) && (wr_row_o == $past(wr_row_o)));

    // R7: column wrap advances the row
    p_stream_row_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o) && s_q.st == ST_STREAM && $past(s_q.st) == ST_STREAM
         && $past(wr_col_o) == COL_LAST)
        |-> (wr_col_o == '0) && (wr_row_o == ADDR_W'($past(wr_row_o) + 1'b1)));

    // R8: code bit 8 and RAM select stay fixed through a stream
    p_stream_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o) && s_q.st == ST_STREAM && $past(s_q.st) == ST_STREAM)
        |-> (wr_code_o[BYTE_W] == $past(wr_code_o[BYTE_W])) && (wr_attr_o == $past(wr_attr_o)));

endmodule

// File: rtl/disp_wr_decoder.sv
module disp_wr_decoder #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_row_o,
    output logic [ADDR_W-1:0] wr_col_o,
    output logic [BYTE_W:0]   wr_code_o,
    output logic              wr_attr_o
);
    logic              is_row, is_stream, sel;
    logic [ADDR_W-1:0] addr_f, row_q, col_q, nrow, ncol;

    dwd_classify #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cls (
        .byte_i     (byte_i),
        .is_row_o   (is_row),
        .is_stream_o(is_stream),
        .sel_o      (sel),
        .addr_o     (addr_f)
    );

    dwd_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .row_i(row_q),
        .col_i(col_q),
        .row_o(nrow),
        .col_o(ncol)
    );

    dwd_seq #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .valid_i    (byte_valid_i),
        .byte_i     (byte_i),
        .is_row_i   (is_row),
        .is_stream_i(is_stream),
        .sel_i      (sel),
        .addr_i     (addr_f),
        .step_row_i (nrow),
        .step_col_i (ncol),
        .row_o      (row_q),
        .col_o      (col_q),
        .wr_en_o    (wr_en_o),
        .wr_row_o   (wr_row_o),
        .wr_col_o   (wr_col_o),
        .wr_code_o  (wr_code_o),
        .wr_attr_o  (wr_attr_o)
    );

endmodule

// File: tb/disp_wr_decoder_test.sv
module disp_wr_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       valid = 1'b0;
    logic [7:0] bdat = 8'h00;
    logic       wr_en;
    logic [4:0] wr_row, wr_col;
    logic [8:0] wr_code;
    logic       wr_attr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    disp_wr_decoder uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .byte_valid_i(valid), .byte_i(bdat),
        .wr_en_o(wr_en), .wr_row_o(wr_row), .wr_col_o(wr_col),
        .wr_code_o(wr_code), .wr_attr_o(wr_attr)
    );

    // req(4) frame valid byte(8) en attr row(5) col(5) code(9)
    function automatic logic [34:0] v(input int rq, input bit f, input bit vl, input logic [7:0] b,
                                      input bit en, input bit at, input int r, input int c, input int d);
        return {4'(rq), f, vl, b, en, at, 5'(r), 5'(c), 9'(d)};
    endfunction

    localparam int NV = 24;
    localparam logic [34:0] VEC [NV] = '{
        v(2, 1,1,8'h83, 0,0, 0, 0, 0),      // R2 row 3 character target
        v(3, 1,1,8'h25, 0,0, 0, 0, 0),      // R3 column 5, bit5 = 1
        v(4, 1,1,8'h41, 1,0, 3, 5, 9'h141), // R4 R5 code {1,41}
        v(6, 1,1,8'hA4, 0,0, 0, 0, 0),      // R6 new row 4, attribute target
        v(3, 1,1,8'h22, 0,0, 0, 0, 0),      // R3 column 2, bit5 ignored
        v(4, 1,1,8'h7F, 1,1, 4, 2, 9'h07F), // R4 attribute bit8 = 0
        v(6, 1,1,8'h09, 0,0, 0, 0, 0),      // R6 column only, row kept
        v(6, 1,1,8'hAA, 1,1, 4, 9, 9'h0AA), // R6 pair write
        v(10,1,0,8'h55, 0,0, 0, 0, 0),      // R10 invalid byte ignored
        v(6, 1,1,8'h0A, 0,0, 0, 0, 0),      // R6 column 10
        v(6, 1,1,8'h12, 1,1, 4,10, 9'h012), // R6 write keeps row 4
        v(2, 1,1,8'h81, 0,0, 0, 0, 0),      // R2 row 1 character
        v(3, 1,1,8'h7E, 0,0, 0, 0, 0),      // R3 stream column 30 bit5 = 1
        v(7, 1,1,8'h10, 1,0, 1,30, 9'h110), // R7 first stream write
        v(8, 1,1,8'h85, 1,0, 1,31, 9'h185), // R8 bit7 byte is data
        v(7, 1,1,8'h00, 1,0, 2, 0, 9'h100), // R7 column wrap, row +1
        v(10,0,1,8'h33, 0,0, 0, 0, 0),      // R10 outside frame
        v(9, 1,1,8'h05, 0,0, 0, 0, 0),      // R9 idle drops column byte
        v(9, 1,1,8'h44, 0,0, 0, 0, 0),      // R9 idle drops stream column byte
        v(2, 1,1,8'h9F, 0,0, 0, 0, 0),      // R2 row 31
        v(3, 1,1,8'h00, 0,0, 0, 0, 0),      // R3 column 0
        v(5, 1,1,8'hC8, 1,0,31, 0, 9'h0C8), // R5 bit7 byte as single data
        v(5, 1,1,8'hC9, 0,0, 0, 0, 0),      // R5 R6 next byte is a row, no write
        v(5, 1,0,8'h00, 0,0, 0, 0, 0)       // R5 strobe lasts one cycle
    };

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // drive at the falling edge, registered on the rising edge, sample at the next falling edge
    task automatic step(input bit f, input bit vl, input logic [7:0] b);
        frame = f; valid = vl; bdat = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_wr(input int rq, input bit en, input bit at, input int r, input int c, input int d);
        check(rq, "wr_en", 32'(wr_en), 32'(en));
        if (en) begin
            check(rq, "row",  32'(wr_row), 32'(r));
            check(rq, "col",  32'(wr_col), 32'(c));
            check(rq, "code", 32'(wr_code), 32'(d));
            check(rq, "attr", 32'(wr_attr), 32'(at));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset and right after
        check(1, "reset outputs", {wr_en, wr_row, wr_col, wr_code, wr_attr}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "post-reset outputs", {wr_en, wr_row, wr_col, wr_code, wr_attr}, '0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][30], VEC[i][29], VEC[i][28:21]);
            expect_wr(int'(VEC[i][34:31]), VEC[i][20], VEC[i][19],
                      int'(VEC[i][18:14]), int'(VEC[i][13:9]), int'(VEC[i][8:0]));
        end

        // R7: row 31 column 31 wraps to row 0 column 0, attribute stream
        step(0, 0, 8'h00);
        step(1, 1, 8'hBF); expect_wr(7, 0, 0, 0, 0, 0);
        step(1, 1, 8'h7F); expect_wr(7, 0, 0, 0, 0, 0);
        step(1, 1, 8'h11); expect_wr(7, 1, 1, 31, 31, 9'h011);
        step(1, 1, 8'h22); expect_wr(7, 1, 1, 0, 0, 9'h022);
        // R10: gap in valid keeps the stream position
        step(1, 0, 8'h99); expect_wr(10, 0, 0, 0, 0, 0);
        step(1, 1, 8'h33); expect_wr(10, 1, 1, 0, 1, 9'h033);
        // R9: frame end leaves streaming; data-looking byte then ignored
        step(0, 0, 8'h00); expect_wr(9, 0, 0, 0, 0, 0);
        step(1, 1, 8'h44); expect_wr(9, 0, 0, 0, 0, 0);
        // R1: reset mid-frame clears the strobe and returns to idle
        step(1, 1, 8'h82);
        step(1, 1, 8'h03);
        rst_n = 1'b0;
        step(1, 1, 8'h55); expect_wr(1, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step(1, 1, 8'h56); expect_wr(1, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule